// File: doc/BRIEF.md
# Weekly Minute Alarm Comparator

This block sits next to a real-time clock counter and watches the running seconds, minutes, hours and day of the week that the counter presents. Software programs an alarm minute and an alarm hour, both in BCD, and a day-of-week mask with one bit per weekday. The alarm is taken at minute resolution: it is due at second zero of the programmed minute. The mask can name any set of weekdays, so an alarm can lie anywhere in the coming week.

When the counter signals a new second, and that second is 00 and the minute, the hour and a selected weekday all agree with the programmed values, the block gives a one-cycle hit pulse. If the alarm enable is set, the hit also sets a sticky interrupt flag. The flag stays high until software acknowledges it by writing a one. The counter is not part of this block.

Top module: `wkal_alarm`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the alarm minute, alarm hour, day mask, enable, hit pulse and interrupt flag are all zero.
- R2: A write with select 0 stores the low 7 bits of the data as the alarm minute. Select 1 stores the low 6 bits as the alarm hour. Select 2 stores the low 7 bits as the day mask. Select 3 loads the enable from data bit 4. Selects 5 to 7 change no register. The stored value appears on the outputs one cycle after the write.
- R3: In a cycle where the second tick is high, the current second is 8'h00, the current minute and hour equal the alarm minute and hour, and the mask bit indexed by the current weekday is 1, the hit pulse is high in the next cycle.
- R4: The hit pulse is high for exactly one cycle per qualifying tick. It never follows a cycle without a tick, or a tick whose second is not 8'h00.
- R5: With several mask bits set, a match on any of the selected weekdays produces a hit. A weekday whose mask bit is 0 does not.
- R6: A current weekday code of 7 or more never produces a hit, even when every mask bit is set.
- R7: The interrupt flag is set one cycle after a hit only when the enable is 1. The hit pulse itself does not depend on the enable.
- R8: The interrupt flag holds its value until a write with select 4 and data bit 0 equal to 1 clears it in the next cycle. A select-4 write with bit 0 equal to 0 has no effect.
- R9: If an acknowledge and an enabled hit fall in the same cycle, the flag is set, so the new event is not lost.
- R10: Writing 0 to the control select (select 3) disables the alarm but leaves a flag that is already set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select: 0 minute, 1 hour, 2 day mask, 3 control, 4 acknowledge |
| wr_data_i | input | 8 | Write data |
| sec_tick_i | input | 1 | High for one cycle when the counter fields have moved to a new second |
| cur_sec_i | input | 8 | Current second, BCD |
| cur_min_i | input | 8 | Current minute, BCD |
| cur_hour_i | input | 8 | Current hour, BCD, 24-hour |
| cur_wday_i | input | 3 | Current weekday, 0 to 6 |
| alm_min_o | output | 8 | Programmed alarm minute |
| alm_hour_o | output | 8 | Programmed alarm hour |
| day_mask_o | output | 7 | Programmed weekday mask |
| alm_en_o | output | 1 | Alarm enable |
| hit_pulse_o | output | 1 | One-cycle alarm match pulse |
| irq_o | output | 1 | Sticky alarm interrupt flag |

## Verification
The assertions take the second tick to be a single-cycle strobe and the current time fields to be stable and valid in the cycle the strobe is high. They take no other property of the inputs on trust, and the weekday code may carry the out-of-range value 7. The stimulus keeps the tick to one cycle and always puts an idle cycle between ticks. It draws weekday codes from the full 3-bit range, so the invalid code is also exercised. It biases the time fields toward the programmed alarm values so that matches and near-misses both occur often.

// File: rtl/wkal_pkg.sv
`timescale 1ns/1ps
package wkal_pkg;
   typedef enum logic [2:0] {
      SEL_MIN  = 3'd0,
      SEL_HOUR = 3'd1,
      SEL_DAYS = 3'd2,
      SEL_CTRL = 3'd3,
      SEL_ACK  = 3'd4
   } wkal_sel_e;

   localparam int CTRL_EN_BIT = 4;
   localparam int ACK_BIT     = 0;
endpackage

// File: rtl/wkal_regs.sv
`timescale 1ns/1ps
module wkal_regs #(
   parameter int BCD_W     = 8,
   parameter int MIN_BITS  = 7,
   parameter int HOUR_BITS = 6,
   parameter int NUM_DAYS  = 7
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                wr_en_i,
   input  logic [2:0]          wr_sel_i,
   input  logic [BCD_W-1:0]    wr_data_i,
   output logic [BCD_W-1:0]    alm_min_o,
   output logic [BCD_W-1:0]    alm_hour_o,
   output logic [NUM_DAYS-1:0] day_mask_o,
   output logic                alm_en_o,
   output logic                ack_o
);
   import wkal_pkg::*;

   localparam logic [BCD_W-1:0] MIN_KEEP  = BCD_W'((1 << MIN_BITS) - 1);
   localparam logic [BCD_W-1:0] HOUR_KEEP = BCD_W'((1 << HOUR_BITS) - 1);

   generate
      if (MIN_BITS > BCD_W || HOUR_BITS > BCD_W || NUM_DAYS > BCD_W) begin : g_bad_width
         $error("wkal_regs: field wider than the write data");
      end
      if (CTRL_EN_BIT >= BCD_W) begin : g_bad_ctrl
         $error("wkal_regs: enable bit outside the write data");
      end
   endgenerate

   logic unused_hi;
   assign unused_hi = ^wr_data_i[BCD_W-1:MIN_BITS];

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         alm_min_o  <= '0;
         alm_hour_o <= '0;
         day_mask_o <= '0;
         alm_en_o   <= 1'b0;
      end else if (wr_en_i) begin
         case (wr_sel_i)
            SEL_MIN:  alm_min_o  <= wr_data_i & MIN_KEEP;
            SEL_HOUR: alm_hour_o <= wr_data_i & HOUR_KEEP;
            SEL_DAYS: day_mask_o <= wr_data_i[NUM_DAYS-1:0];
            SEL_CTRL: alm_en_o   <= wr_data_i[CTRL_EN_BIT];
            default:  ;
         endcase
      end
   end

   assign ack_o = wr_en_i && (wr_sel_i == SEL_ACK) && wr_data_i[ACK_BIT];

   // R2: without a write strobe no programmed value moves
   assert_cfg_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_i |=> $stable({alm_min_o, alm_hour_o, day_mask_o, alm_en_o}));
endmodule

// File: rtl/wkal_match.sv
`timescale 1ns/1ps
module wkal_match #(
   parameter int BCD_W    = 8,
   parameter int NUM_DAYS = 7,
   parameter int WDAY_W   = 3
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                sec_tick_i,
   input  logic [BCD_W-1:0]    cur_sec_i,
   input  logic [BCD_W-1:0]    cur_min_i,
   input  logic [BCD_W-1:0]    cur_hour_i,
   input  logic [WDAY_W-1:0]   cur_wday_i,
   input  logic [BCD_W-1:0]    alm_min_i,
   input  logic [BCD_W-1:0]    alm_hour_i,
   input  logic [NUM_DAYS-1:0] day_mask_i,
   output logic                hit_o
);
   logic [NUM_DAYS-1:0] day_hit;

   generate
      if ((1 << WDAY_W) < NUM_DAYS) begin : g_bad_wday
         $error("wkal_match: weekday code too narrow");
      end
      for (genvar d = 0; d < NUM_DAYS; d++) begin : g_day
         assign day_hit[d] = day_mask_i[d] && (cur_wday_i == WDAY_W'(d));
      end
   endgenerate

   logic time_eq;
   assign time_eq = (cur_sec_i == '0) && (cur_min_i == alm_min_i) && (cur_hour_i == alm_hour_i);
   assign hit_o   = sec_tick_i && time_eq && (|day_hit);

   // R6: an out-of-range weekday code never matches
   assert_no_bad_day_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (32'(cur_wday_i) >= NUM_DAYS) |-> !hit_o);
endmodule

// File: rtl/wkal_flag.sv
`timescale 1ns/1ps
module wkal_flag (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic hit_i,
   input  logic en_i,
   input  logic ack_i,
   output logic pulse_o,
   output logic irq_o
);
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         pulse_o <= 1'b0;
         irq_o   <= 1'b0;
      end else begin
         pulse_o <= hit_i;
         if (hit_i && en_i)
            irq_o <= 1'b1;
         else if (ack_i)
            irq_o <= 1'b0;
      end
   end

   assert_set_needs_en_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o) |-> $past(hit_i && en_i));
   assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o && !ack_i) |=> irq_o);
   assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i && !(hit_i && en_i)) |=> !irq_o);
   assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_i && en_i) |=> irq_o);
endmodule

// File: rtl/wkal_alarm.sv
`timescale 1ns/1ps
module wkal_alarm #(
   parameter int BCD_W     = 8,
   parameter int MIN_BITS  = 7,
   parameter int HOUR_BITS = 6,
   parameter int NUM_DAYS  = 7,
   parameter int WDAY_W    = 3
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                wr_en_i,
   input  logic [2:0]          wr_sel_i,
   input  logic [BCD_W-1:0]    wr_data_i,
   input  logic                sec_tick_i,
   input  logic [BCD_W-1:0]    cur_sec_i,
   input  logic [BCD_W-1:0]    cur_min_i,
   input  logic [BCD_W-1:0]    cur_hour_i,
   input  logic [WDAY_W-1:0]   cur_wday_i,
   output logic [BCD_W-1:0]    alm_min_o,
   output logic [BCD_W-1:0]    alm_hour_o,
   output logic [NUM_DAYS-1:0] day_mask_o,
   output logic                alm_en_o,
   output logic                hit_pulse_o,
   output logic                irq_o
);
   logic hit, ack;

   wkal_regs #(.BCD_W(BCD_W), .MIN_BITS(MIN_BITS), .HOUR_BITS(HOUR_BITS), .NUM_DAYS(NUM_DAYS)) u_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (wr_en_i),
      .wr_sel_i   (wr_sel_i),
      .wr_data_i  (wr_data_i),
      .alm_min_o  (alm_min_o),
      .alm_hour_o (alm_hour_o),
      .day_mask_o (day_mask_o),
      .alm_en_o   (alm_en_o),
      .ack_o      (ack)
   );

   wkal_match #(.BCD_W(BCD_W), .NUM_DAYS(NUM_DAYS), .WDAY_W(WDAY_W)) u_match (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sec_tick_i (sec_tick_i),
      .cur_sec_i  (cur_sec_i),
      .cur_min_i  (cur_min_i),
      .cur_hour_i (cur_hour_i),
      .cur_wday_i (cur_wday_i),
      .alm_min_i  (alm_min_o),
      .alm_hour_i (alm_hour_o),
      .day_mask_i (day_mask_o),
      .hit_o      (hit)
   );

   wkal_flag u_flag (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .hit_i   (hit),
      .en_i    (alm_en_o),
      .ack_i   (ack),
      .pulse_o (hit_pulse_o),
      .irq_o   (irq_o)
   );

   // R4: a hit pulse only follows a tick at second zero
   assert_pulse_zero_sec_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_pulse_o |-> $past(sec_tick_i && (cur_sec_i == '0)));
   // R10: disabling leaves a pending flag in place
   assert_disable_keeps_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o && wr_en_i && wr_sel_i == 3'd3) |=> irq_o);
endmodule

// File: tb/wkal_alarm_tb.sv
`timescale 1ns/1ps
module wkal_alarm_tb;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       wr_en;
   logic [2:0] wr_sel;
   logic [7:0] wr_data;
   logic       tick;
   logic [7:0] sec, mn, hr;
   logic [2:0] wd;
   logic [7:0] o_min, o_hour;
   logic [6:0] o_mask;
   logic       o_en, o_pulse, o_irq;

   int n_run  = 0;
   int n_fail = 0;

   logic [7:0] m_min = 0, m_hour = 0;
   logic [6:0] m_mask = 0;
   logic       m_en = 0, m_irq = 0, m_pulse = 0;

   always #10 clk = ~clk;

   wkal_alarm u_dut (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
      .sec_tick_i(tick), .cur_sec_i(sec), .cur_min_i(mn), .cur_hour_i(hr), .cur_wday_i(wd),
      .alm_min_o(o_min), .alm_hour_o(o_hour), .day_mask_o(o_mask), .alm_en_o(o_en),
      .hit_pulse_o(o_pulse), .irq_o(o_irq)
   );

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic chk_all(string tag);
      chk(tag, "pulse", 32'(o_pulse), 32'(m_pulse));
      chk(tag, "irq", 32'(o_irq), 32'(m_irq));
      chk(tag, "min", 32'(o_min), 32'(m_min));
      chk(tag, "hour", 32'(o_hour), 32'(m_hour));
      chk(tag, "mask", 32'(o_mask), 32'(m_mask));
      chk(tag, "en", 32'(o_en), 32'(m_en));
   endtask

   function automatic bit exp_hit(bit tk, logic [7:0] s, logic [7:0] m, logic [7:0] h, logic [2:0] w);
      return tk && s == 8'h00 && m == m_min && h == m_hour && w < 3'd7 && m_mask[w];
   endfunction

   // Called at a falling edge: drives one cycle, checks, then idles one cycle.
   task automatic step(string tag, bit tk, logic [7:0] s, logic [7:0] m, logic [7:0] h,
                       logic [2:0] w, bit we, logic [2:0] sl, logic [7:0] d);
      bit hit;
      tick = tk; sec = s; mn = m; hr = h; wd = w;
      wr_en = we; wr_sel = sl; wr_data = d;
      hit = exp_hit(tk, s, m, h, w);
      m_pulse = hit;
      if (hit && m_en) m_irq = 1'b1;
      else if (we && sl == 3'd4 && d[0]) m_irq = 1'b0;
      if (we) begin
         case (sl)
            3'd0: m_min  = d & 8'h7F;
            3'd1: m_hour = d & 8'h3F;
            3'd2: m_mask = d[6:0];
            3'd3: m_en   = d[4];
            default: ;
         endcase
      end
      @(negedge clk);
      chk_all(tag);
      tick = 1'b0; wr_en = 1'b0;
      m_pulse = 1'b0;
      @(negedge clk);
      chk(tag, "pulse one cycle (R4)", 32'(o_pulse), 32'd0);
   endtask

   task automatic wr(string tag, logic [2:0] sl, logic [7:0] d);
      step(tag, 1'b0, 8'h00, 8'h00, 8'h00, 3'd0, 1'b1, sl, d);
   endtask

   initial begin
      #(20 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      rst_n = 1'b0; wr_en = 0; wr_sel = 0; wr_data = 0;
      tick = 0; sec = 0; mn = 0; hr = 0; wd = 0;
      repeat (3) @(negedge clk);
      chk_all("R1");
      rst_n = 1'b1;
      @(negedge clk);
      chk_all("R1");

      // R2 register writes and masking
      wr("R2", 3'd0, 8'hC5);
      wr("R2", 3'd1, 8'hE3);
      wr("R2", 3'd2, 8'h08);
      wr("R2", 3'd3, 8'h10);
      wr("R2", 3'd5, 8'hFF);
      wr("R2", 3'd7, 8'h00);
      // R3 exact match on weekday 3
      step("R3", 1, 8'h00, 8'h45, 8'h23, 3'd3, 0, 3'd0, 8'h00);
      // R8 acknowledge with bit 0 clear does nothing, then real clear
      wr("R8", 3'd4, 8'hFE);
      wr("R8", 3'd4, 8'h01);
      // R4 second not zero, and no tick
      step("R4", 1, 8'h01, 8'h45, 8'h23, 3'd3, 0, 3'd0, 8'h00);
      step("R4", 0, 8'h00, 8'h45, 8'h23, 3'd3, 0, 3'd0, 8'h00);
      // R6 invalid weekday with full mask
      wr("R6", 3'd2, 8'hFF);
      step("R6", 1, 8'h00, 8'h45, 8'h23, 3'd7, 0, 3'd0, 8'h00);
      // R5 two selected days
      wr("R5", 3'd2, 8'h41);
      step("R5", 1, 8'h00, 8'h45, 8'h23, 3'd6, 0, 3'd0, 8'h00);
      wr("R5", 3'd4, 8'h01);
      step("R5", 1, 8'h00, 8'h45, 8'h23, 3'd0, 0, 3'd0, 8'h00);
      step("R5", 1, 8'h00, 8'h45, 8'h23, 3'd3, 0, 3'd0, 8'h00);
      // R10 disable keeps pending flag
      wr("R10", 3'd3, 8'h00);
      step("R10", 1, 8'h00, 8'h45, 8'h23, 3'd0, 0, 3'd0, 8'h00);
      wr("R7", 3'd4, 8'h01);
      // R7 hit while disabled: pulse, no flag
      step("R7", 1, 8'h00, 8'h45, 8'h23, 3'd0, 0, 3'd0, 8'h00);
      // R9 enabled hit and acknowledge together
      wr("R9", 3'd3, 8'h10);
      step("R9", 1, 8'h00, 8'h45, 8'h23, 3'd6, 1, 3'd4, 8'h01);
      // R10 control write with bit 4 low disables
      wr("R10", 3'd3, 8'hEF);

      // Random mix
      for (int i = 0; i < 500; i++) begin
         bit tk, we;
         logic [7:0] s, m, h, d;
         logic [2:0] w, sl;
         tk = ($urandom % 10) < 7;
         s  = (($urandom % 10) < 6) ? 8'h00 : 8'($urandom % 8'h5A);
         m  = (($urandom % 2) == 0) ? m_min : 8'($urandom % 8'h5A);
         h  = (($urandom % 2) == 0) ? m_hour : 8'($urandom % 8'h24);
         w  = 3'($urandom % 8);
         we = ($urandom % 5) == 0;
         sl = 3'($urandom % 8);
         d  = 8'($urandom);
         step("R3", tk, s, m, h, w, we, sl, d);
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule